// File: doc/BRIEF.md
# Incremental Phase Step Controller

This block holds a digital phase offset code for an output clock and moves it one step at a time. Each rising edge on an asynchronous step input moves the code by one unit. An asynchronous direction input, sampled with that edge, chooses between delaying the output (code counts up) and advancing it (code counts down). The code wraps around a modulus equal to the number of steps in one full output period. That modulus is set by the operating mode, which is multiply or divide, and by a 2-bit ratio select. The code is meant to drive a delay line outside this block.

Both asynchronous inputs pass through a two-flop synchroniser. The step edge is then detected in the system clock domain. A 5-bit counter tracks detected edges, and every 32nd edge is deliberately dropped without changing the code. A one-cycle strobe marks each cycle in which the code really changes. A bypass input turns the stepping function off while it is high. Any change of mode or ratio returns the controller to its starting state.

Top module: `phase_step_ctrl`

## Requirements
- R1: After reset, `phase_code` is 0 and `step_strobe` is 0.
- R2: A step edge taken with `dir_in` low (delay) raises the code by 1. The new value appears on the third rising clock edge after `step_in` rises, with `dir_in` held stable over the same window.
- R3: A step edge taken with `dir_in` high (advance) lowers the code by 1, with the same latency as R2.
- R4: With `div_mode` = 0 (multiply), the period is 384 steps for every `ratio_sel`. A delay from 383 gives 0, and 99 consecutive delay edges after a clear (96 applied, 3 dropped) give 96.
- R5: With `div_mode` = 1 (divide), the period is 3072 steps for `ratio_sel` = 0 (divide by 2), 6144 for `ratio_sel` = 1 (divide by 3), and 12288 for `ratio_sel` = 2 or 3 (divide by 4).
- R6: An advance from code 0 gives the period minus one in every mode.
- R7: Counting detected edges since the last clear, edge 32, 64, 96 and so on leaves the code unchanged. The edge counter advances on dropped edges as well.
- R8: `step_strobe` is high for exactly one cycle, in the cycle the new code first appears, for each applied step. It stays low on dropped edges.
- R9: While `bypass` is high, step edges change neither the code nor the edge count, and produce no strobe.
- R10: A change of `div_mode` or `ratio_sel` clears both the code and the edge counter to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_in | input | 1 | Asynchronous step request; each rising edge is one step |
| dir_in | input | 1 | Asynchronous direction: 0 delays, 1 advances |
| bypass | input | 1 | High turns off stepping (phase alignment bypassed) |
| div_mode | input | 1 | 0 multiply mode, 1 divide mode |
| ratio_sel | input | 2 | Ratio select; in divide mode 0 = /2, 1 = /3, 2 or 3 = /4 |
| phase_code | output | 14 | Wrapped phase offset code |
| step_strobe | output | 1 | One-cycle pulse when the code changes |

## Verification
Several rules are checked by assertions on every cycle. The code never leaves the range of the active period. A strobe appears only after a detected, non-dropped edge, and the code always moves when it does. A dropped edge or a bypassed cycle leaves the code and strobe quiet. A configuration change clears the code on the next edge, and the edge counter steps by one per counted edge. The bench scenarios are needed for the rest: the exact arithmetic of wrap-around in each of the four periods, the position of dropped edges within long runs, the synchroniser latency, and the fact that bypassed edges do not move the 32-edge pattern.

// File: rtl/phstep_pkg.sv
package phstep_pkg;

    typedef struct packed {
        logic       div_mode;
        logic [1:0] ratio;
    } cfg_t;

endpackage

// File: rtl/phstep_sync.sv
module phstep_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } bit_state_t;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        bit_state_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.chain = {st_q.chain[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign sync_o[b] = st_q.chain[STAGES-1];
    end

endmodule

// File: rtl/phstep_modsel.sv
module phstep_modsel
    import phstep_pkg::*;
#(
    parameter int CODE_W     = 14,
    parameter int MULT_STEPS = 384,
    parameter int DIV_BASE   = 3072
) (
    input  cfg_t              cfg_i,
    output logic [CODE_W-1:0] max_code_o
);

    localparam logic [CODE_W-1:0] MAX_MULT = CODE_W'(MULT_STEPS - 1);
    localparam logic [CODE_W-1:0] MAX_DIV2 = CODE_W'(DIV_BASE - 1);
    localparam logic [CODE_W-1:0] MAX_DIV3 = CODE_W'(2 * DIV_BASE - 1);
    localparam logic [CODE_W-1:0] MAX_DIV4 = CODE_W'(4 * DIV_BASE - 1);

    always_comb begin
        if (!cfg_i.div_mode) begin
            max_code_o = MAX_MULT;
        end else begin
            unique case (cfg_i.ratio)
                2'd0:    max_code_o = MAX_DIV2;
                2'd1:    max_code_o = MAX_DIV3;
                default: max_code_o = MAX_DIV4;
            endcase
        end
    end

endmodule

// File: rtl/phstep_skipcnt.sv
module phstep_skipcnt #(
    parameter int SKIP_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    output logic skip_o
);

    typedef struct packed {
        logic [SKIP_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i)      st_d.cnt = '0;
        else if (count_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign skip_o = &st_q.cnt;

    // R7: each counted edge moves the count by one, dropped edges included
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i && !clear_i) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R10: a clear request empties the counter
    p_count_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
    import phstep_pkg::*;
#(
    parameter int CODE_W     = 14,
    parameter int SKIP_W     = 5,
    parameter int MULT_STEPS = 384,
    parameter int DIV_BASE   = 3072
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_in,
    input  logic              dir_in,
    input  logic              bypass,
    input  logic              div_mode,
    input  logic [1:0]        ratio_sel,
    output logic [CODE_W-1:0] phase_code,
    output logic              step_strobe
);

    localparam int SYNC_W = 2;

    typedef struct packed {
        logic [CODE_W-1:0] phase;
        logic              strobe;
        logic              step_prev;
        cfg_t              cfg;
    } state_t;

    state_t             st_d, st_q;
    logic [SYNC_W-1:0]  sync_v;
    logic               step_s, dir_s;
    logic [CODE_W-1:0]  max_code;
    logic               cfg_chg, edge_ok, skip;
    cfg_t               cfg_in;

    assign cfg_in = '{div_mode: div_mode, ratio: ratio_sel};

    phstep_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dir_in, step_in}),
        .sync_o  (sync_v)
    );

    assign step_s = sync_v[0];
    assign dir_s  = sync_v[1];

    phstep_modsel #(
        .CODE_W(CODE_W), .MULT_STEPS(MULT_STEPS), .DIV_BASE(DIV_BASE)
    ) u_modsel (
        .cfg_i      (st_q.cfg),
        .max_code_o (max_code)
    );

    phstep_skipcnt #(.SKIP_W(SKIP_W)) u_skip (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cfg_chg),
        .count_i (edge_ok),
        .skip_o  (skip)
    );

    always_comb begin
        cfg_chg = (cfg_in != st_q.cfg);
        edge_ok = step_s && !st_q.step_prev && !bypass && !cfg_chg;

        st_d           = st_q;
        st_d.strobe    = 1'b0;
        st_d.step_prev = step_s;
        st_d.cfg       = cfg_in;

        if (cfg_chg) begin
            st_d.phase = '0;
        end else if (edge_ok && !skip) begin
            st_d.strobe = 1'b1;
            if (dir_s) begin
                st_d.phase = (st_q.phase == '0) ? max_code : st_q.phase - 1'b1;
            end else begin
                st_d.phase = (st_q.phase == max_code) ? '0 : st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_code  = st_q.phase;
    assign step_strobe = st_q.strobe;

    // R5: the code stays inside the active period
    p_code_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_code <= max_code);

    // R8: a strobe follows only a counted edge that was not dropped
    p_strobe_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_strobe |-> $past(edge_ok && !skip));

    // R2: a strobe always comes with a moved code
    p_strobe_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_strobe |-> (phase_code != $past(phase_code)));

    // R7: a dropped edge leaves the code alone
    p_skip_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(edge_ok && skip) |-> (!step_strobe && $stable(phase_code)));

    // R9: bypass freezes the code
    p_bypass_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bypass && !cfg_chg) |-> (!step_strobe && $stable(phase_code)));

    // R10: configuration change clears the code
    p_cfg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (phase_code == '0));

endmodule

// File: tb/phase_step_ctrl_test.sv
module phase_step_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_in = 1'b0;
    logic        dir_in = 1'b0;
    logic        bypass = 1'b0;
    logic        div_mode = 1'b0;
    logic [1:0]  ratio_sel = 2'd0;
    logic [13:0] phase_code;
    logic        step_strobe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int exp_phase = 0;
    int exp_cnt   = 0;

    always #4 clk = ~clk;

    phase_step_ctrl uut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
        .bypass(bypass), .div_mode(div_mode), .ratio_sel(ratio_sel),
        .phase_code(phase_code), .step_strobe(step_strobe)
    );

    function automatic int period_of(logic dm, logic [1:0] rs);
        if (!dm) return 384;
        case (rs)
            2'd0:    return 3072;
            2'd1:    return 6144;
            default: return 12288;
        endcase
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one step pulse; samples at the negedge after the third posedge
    task automatic do_step(logic dir, string req);
        bit applied;
        int per;
        per = period_of(div_mode, ratio_sel);
        dir_in  = dir;
        step_in = 1'b1;
        repeat (3) @(negedge clk);
        applied = 1'b0;
        if (!bypass) begin
            if (exp_cnt != 31) begin
                applied = 1'b1;
                if (dir) exp_phase = (exp_phase == 0) ? per - 1 : exp_phase - 1;
                else     exp_phase = (exp_phase == per - 1) ? 0 : exp_phase + 1;
            end
            exp_cnt = (exp_cnt + 1) % 32;
        end
        check_eq({req, " code"}, int'(phase_code), exp_phase);
        check_eq({req, " strobe"}, int'(step_strobe), int'(applied));
        step_in = 1'b0;
        repeat (3) @(negedge clk);
        check_eq({req, " strobe width R8"}, int'(step_strobe), 0);
    endtask

    task automatic set_cfg(logic dm, logic [1:0] rs);
        bit changed;
        changed = (dm != div_mode) || (rs != ratio_sel);
        div_mode  = dm;
        ratio_sel = rs;
        repeat (2) @(negedge clk);
        if (changed) begin
            exp_phase = 0;
            exp_cnt   = 0;
            check_eq("R10 clear on config change", int'(phase_code), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 reset code", int'(phase_code), 0);
        check_eq("R1 reset strobe", int'(step_strobe), 0);

        // R2 / R3 basic direction
        do_step(1'b0, "R2 delay");
        do_step(1'b0, "R2 delay");
        do_step(1'b1, "R3 advance");

        // R4: 99 delay edges from clear give 96 (R7 drops 3)
        set_cfg(1'b0, 2'd1);
        for (int i = 0; i < 99; i++) do_step(1'b0, "R4 R7 delay run");
        check_eq("R4 quarter period", int'(phase_code), 96);
        // continue delaying through the 383 -> 0 wrap
        while (exp_phase != 383) do_step(1'b0, "R4 R7 toward wrap");
        check_eq("R4 at max", int'(phase_code), 383);
        if (exp_cnt == 31) do_step(1'b0, "R7 dropped before wrap");
        do_step(1'b0, "R4 wrap to zero");
        check_eq("R4 wrapped", int'(phase_code), 0);

        // R6 / R5 advance from 0 in each mode
        set_cfg(1'b0, 2'd3);
        do_step(1'b1, "R6 multiply advance wrap");
        check_eq("R6 mult max", int'(phase_code), 383);
        set_cfg(1'b1, 2'd0);
        do_step(1'b1, "R5 R6 div2 wrap");
        check_eq("R5 div2 max", int'(phase_code), 3071);
        set_cfg(1'b1, 2'd1);
        do_step(1'b1, "R5 R6 div3 wrap");
        check_eq("R5 div3 max", int'(phase_code), 6143);
        set_cfg(1'b1, 2'd2);
        do_step(1'b1, "R5 R6 div4 wrap");
        check_eq("R5 div4 max", int'(phase_code), 12287);
        set_cfg(1'b1, 2'd3);
        do_step(1'b1, "R5 R6 div4 alt wrap");
        check_eq("R5 div4 alt max", int'(phase_code), 12287);
        do_step(1'b0, "R5 div4 delay back to 0");

        // R9: bypassed edges move nothing, edge pattern unchanged
        set_cfg(1'b0, 2'd0);
        for (int i = 0; i < 30; i++) do_step(1'b0, "R9 prefill");
        bypass = 1'b1;
        for (int i = 0; i < 5; i++) do_step(i[0], "R9 bypassed");
        bypass = 1'b0;
        do_step(1'b0, "R9 edge 31 applies");
        do_step(1'b0, "R7 R9 edge 32 dropped");
        check_eq("R9 code after bypass", int'(phase_code), 31);

        // random mix
        for (int i = 0; i < 500; i++) begin
            if (($urandom % 60) == 0)
                set_cfg(1'($urandom % 2), 2'($urandom % 4));
            bypass = (($urandom % 10) == 0);
            do_step(1'($urandom % 2), "R2 R3 R7 R9 random");
        end
        bypass = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule